// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs one serial flash command each time software asks for one. Software first loads a command opcode register and a 24-bit address register. For a program-style command it also fills a word-addressed data buffer. It then writes a configuration word that describes the whole transaction and carries a self-clearing start bit.

The engine drives one chip-select line low and shifts out the opcode. It follows with an optional three-byte address, a number of zero-valued dummy bytes, and an optional data phase in either direction. After the last bit it releases chip select and clears the start bit. For a read, the received bytes are already in the buffer by then.

Before a command that carries an address is issued, the address is compared against a fixed protected window. A hit aborts the command and latches a status flag. A program failure reported by the flash side also latches a flag. Both flags stay set until software clears them through a clear register. Byte-wide shifting on the single serial lane is done by a separate shifter sub-block.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, the configuration (0x300), opcode (0x308), address (0x30C) and status (0x120) registers read 0. All `cs_n` lines are high and `sck` is low.
- R2: Bit 0 of the configuration register reads 1 from the write that starts a command until the command ends, and 0 afterwards. Chip select stays low for the whole command and rises exactly one serial clock period (two `clk` cycles) after the last falling `sck` edge.
- R3: A command goes out in this order: the opcode; then, if configuration bit 3 is set, the address bytes [23:16], [15:8] and [7:0]; then as many 0x00 bytes as configuration bits 6:4 give; then the data phase if bit 7 is set. Each byte goes out MSB first in SPI mode 0, with `sck` at half the `clk` rate, so a command of N bytes gives 8·N rising `sck` edges.
- R4: Configuration bits 2:1 select which `cs_n` line goes low, and only that line goes low.
- R5: With bit 7 set and bit 8 clear, the data phase sends (bits 9 upward) + 1 bytes from the buffer. Byte k is taken from bits 8·(k mod 4)+7 : 8·(k mod 4) of buffer word k/4, and buffer word i sits at offset 0x400 + 4·i. This holds up to the full buffer of 4·BUF_WORDS bytes.
- R6: With bits 7 and 8 both set, received data bytes are stored in the buffer with the same packing. In a partially filled last word, the upper bytes keep their earlier contents.
- R7: While a command is in progress, writes to the opcode, address, configuration and buffer registers are ignored, and a new start request has no effect.
- R8: A start request with bit 3 set whose address lies inside [PROT_LO, PROT_HI] sets status bit 5. No chip select goes low and bit 0 reads 0 right away. An address just below PROT_LO runs normally.
- R9: When a write-data command (bit 7 set, bit 8 clear) ends while `pp_fail` is high, status bit 2 is set. A read command or a command with no data phase never sets it.
- R10: Status bits are sticky. Writing a value to the clear register (0x12C) clears exactly the status bits that are 1 in that value, so 0xFF clears all of them.
- R11: The version register (0x1F8) reads 0x351 when BUF_WORDS is 64, and 0x350 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 12 | Register byte offset, word aligned |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| pp_fail | input | 1 | Program-failure flag from the flash side |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
Write commands are run three ways. One uses an address, a dummy byte and a six-byte partial-word payload, which separates the phase ordering from the byte packing. One uses a full 64-byte buffer, which exposes off-by-one errors in the byte count. One uses a single byte, to probe the program-failure flag. Read commands are run once over a word that was pre-filled, to show that the upper bytes of a partial word are kept. They are also run long enough to hit the engine with register writes and a second start while it is busy. Protected-window commands are tried just below and exactly at the lower bound, and partial and full clears show that the status bits are independent and sticky.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam logic [11:0] OFS_STAT = 12'h120;
  localparam logic [11:0] OFS_CLR  = 12'h12C;
  localparam logic [11:0] OFS_VER  = 12'h1F8;
  localparam logic [11:0] OFS_CFG  = 12'h300;
  localparam logic [11:0] OFS_OPC  = 12'h308;
  localparam logic [11:0] OFS_ADR  = 12'h30C;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SHIFT, SQ_TAIL} seq_e;

  // bytes ahead of the data phase: opcode, optional address, dummies
  function automatic logic [7:0] hdr_len(input logic aen, input logic [2:0] dmy);
    return 8'd1 + (aen ? 8'd3 : 8'd0) + {5'd0, dmy};
  endfunction

  function automatic logic in_window(input logic [23:0] a, input logic [23:0] lo,
                                     input logic [23:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // byte sent at transaction position pos
  function automatic logic [7:0] pick_tx(input logic [9:0] pos, input logic aen,
                                         input logic [7:0] hdr, input logic [7:0] opc,
                                         input logic [23:0] adr, input logic [7:0] dbyte);
    if (pos == 10'd0) return opc;
    if (aen && pos <= 10'd3) begin
      case (pos[1:0])
        2'd1:    return adr[23:16];
        2'd2:    return adr[15:8];
        default: return adr[7:0];
      endcase
    end
    if (pos < {2'b00, hdr}) return 8'h00;
    return dbyte;
  endfunction
endpackage

// File: rtl/fce_bit_shifter.sv
module fce_bit_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       done
);
  logic       active_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q;

  assign mosi = sh_q[7];
  assign done = active_q && (cnt_q == 4'd15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      rx_byte  <= '0;
      sck      <= 1'b0;
    end else if (go) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      sh_q     <= tx_byte;
      sck      <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q + 4'd1;
      if (!cnt_q[0]) begin
        sck     <= 1'b1;
        rx_byte <= {rx_byte[6:0], miso};
      end else begin
        sck  <= 1'b0;
        sh_q <= {sh_q[6:0], 1'b0};
        if (cnt_q == 4'd15) active_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fce_data_buf.sv
module fce_data_buf #(
  parameter int WORDS = 16,
  localparam int IDX_W = $clog2(WORDS),
  localparam int BYTE_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [IDX_W-1:0]  bus_widx,
  input  logic [31:0]       bus_wdata,
  input  logic              eng_we,
  input  logic [BYTE_W-1:0] eng_bidx,
  input  logic [7:0]        eng_byte,
  input  logic [IDX_W-1:0]  rd_widx,
  output logic [31:0]       rd_word,
  input  logic [BYTE_W-1:0] tx_bidx,
  output logic [7:0]        tx_byte
);
  logic [31:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (bus_we && bus_widx == IDX_W'(g))
        word_q <= bus_wdata;
      else if (eng_we && eng_bidx[BYTE_W-1:2] == IDX_W'(g))
        word_q[8*eng_bidx[1:0] +: 8] <= eng_byte;
    end
    assign words[g] = word_q;
  end

  assign rd_word = words[rd_widx];
  assign tx_byte = words[tx_bidx[BYTE_W-1:2]][8*tx_bidx[1:0] +: 8];
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import fce_pkg::*;
#(
  parameter int          BUF_WORDS = 16,
  parameter int          NUM_CS    = 4,
  parameter logic [23:0] PROT_LO   = 24'hFF0000,
  parameter logic [23:0] PROT_HI   = 24'hFFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              pp_fail,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int IDX_W   = $clog2(BUF_WORDS);
  localparam int BYTE_W  = IDX_W + 2;
  localparam int CFG_TOP = 8 + BYTE_W;
  localparam logic [31:0] VERSION = (BUF_WORDS == 64) ? 32'h351 : 32'h350;

  logic [CFG_TOP:1] cfg_q;
  logic [7:0]       opc_q;
  logic [23:0]      adr_q;
  logic [7:0]       stat_q;
  logic             busy_q, cs_act_q, go_q, tcnt_q;
  seq_e             st_q;
  logic [9:0]       pos_q;

  // register decode
  logic aligned, buf_hit, wr_cfg, wr_opc, wr_adr, wr_clr, wr_buf;
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign buf_hit = aligned && (reg_addr[11:10] == 2'b01) && (32'(reg_addr[9:2]) < BUF_WORDS);
  assign wr_cfg  = reg_wr && aligned && (reg_addr == OFS_CFG);
  assign wr_opc  = reg_wr && aligned && (reg_addr == OFS_OPC);
  assign wr_adr  = reg_wr && aligned && (reg_addr == OFS_ADR);
  assign wr_clr  = reg_wr && aligned && (reg_addr == OFS_CLR);
  assign wr_buf  = reg_wr && buf_hit && !busy_q;

  // configuration fields
  logic              f_aen, f_den, f_rd;
  logic [2:0]        f_dmy;
  logic [1:0]        f_sel;
  logic [BYTE_W-1:0] f_cnt;
  assign f_sel = cfg_q[2:1];
  assign f_aen = cfg_q[3];
  assign f_dmy = cfg_q[6:4];
  assign f_den = cfg_q[7];
  assign f_rd  = cfg_q[8];
  assign f_cnt = cfg_q[CFG_TOP:9];

  logic [7:0] hdr;
  logic [9:0] total;
  assign hdr   = hdr_len(f_aen, f_dmy);
  assign total = {2'b00, hdr} + (f_den ? 10'(f_cnt) + 10'd1 : 10'd0);

  // named events
  logic start_req, prot_hit, start_ok, abort_evt, sh_done, last_byte, finish_evt, data_ph, eng_we;
  assign start_req  = wr_cfg && reg_wdata[0] && !busy_q;
  assign prot_hit   = reg_wdata[3] && in_window(adr_q, PROT_LO, PROT_HI);
  assign start_ok   = start_req && !prot_hit;
  assign abort_evt  = start_req && prot_hit;
  assign last_byte  = sh_done && (pos_q + 10'd1 == total);
  assign finish_evt = (st_q == SQ_TAIL) && tcnt_q;
  assign data_ph    = (pos_q >= {2'b00, hdr});
  assign eng_we     = sh_done && data_ph && f_den && f_rd;

  logic [BYTE_W-1:0] dbidx;
  logic [7:0]        dbyte, tx_byte, rx_byte;
  logic [31:0]       buf_rd;
  assign dbidx   = BYTE_W'(pos_q - {2'b00, hdr});
  assign tx_byte = pick_tx(pos_q, f_aen, hdr, opc_q, adr_q, dbyte);

  fce_data_buf #(.WORDS(BUF_WORDS)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .bus_we(wr_buf), .bus_widx(reg_addr[2 +: IDX_W]), .bus_wdata(reg_wdata),
    .eng_we(eng_we), .eng_bidx(dbidx), .eng_byte(rx_byte),
    .rd_widx(reg_addr[2 +: IDX_W]), .rd_word(buf_rd),
    .tx_bidx(dbidx), .tx_byte(dbyte)
  );

  fce_bit_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .go(go_q), .tx_byte(tx_byte), .miso(miso),
    .sck(sck), .mosi(mosi), .rx_byte(rx_byte), .done(sh_done)
  );

  // software-visible registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      opc_q  <= '0;
      adr_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr_cfg && !busy_q) cfg_q <= reg_wdata[CFG_TOP:1];
      if (wr_opc && !busy_q) opc_q <= reg_wdata[7:0];
      if (wr_adr && !busy_q) adr_q <= reg_wdata[23:0];
      if (wr_clr) stat_q <= stat_q & ~reg_wdata[7:0];
      if (abort_evt) stat_q[5] <= 1'b1;
      if (finish_evt && f_den && !f_rd && pp_fail) stat_q[2] <= 1'b1;
    end
  end

  // command sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      busy_q   <= 1'b0;
      cs_act_q <= 1'b0;
      go_q     <= 1'b0;
      tcnt_q   <= 1'b0;
      pos_q    <= '0;
    end else begin
      go_q <= 1'b0;
      case (st_q)
        SQ_IDLE: if (start_ok) begin
          st_q     <= SQ_SHIFT;
          busy_q   <= 1'b1;
          cs_act_q <= 1'b1;
          pos_q    <= '0;
          go_q     <= 1'b1;
        end
        SQ_SHIFT: if (sh_done) begin
          if (last_byte) begin
            st_q   <= SQ_TAIL;
            tcnt_q <= 1'b0;
          end else begin
            pos_q <= pos_q + 10'd1;
            go_q  <= 1'b1;
          end
        end
        default: begin
          tcnt_q <= 1'b1;
          if (tcnt_q) begin
            st_q     <= SQ_IDLE;
            busy_q   <= 1'b0;
            cs_act_q <= 1'b0;
          end
        end
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = ~(cs_act_q && (f_sel == 2'(g)));
  end

  always_comb begin
    reg_rdata = '0;
    if (buf_hit) reg_rdata = buf_rd;
    else if (aligned) begin
      case (reg_addr)
        OFS_CFG: begin
          reg_rdata[CFG_TOP:1] = cfg_q;
          reg_rdata[0]         = busy_q;
        end
        OFS_OPC:  reg_rdata = {24'd0, opc_q};
        OFS_ADR:  reg_rdata = {8'd0, adr_q};
        OFS_STAT: reg_rdata = {24'd0, stat_q};
        OFS_VER:  reg_rdata = VERSION;
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fce_checks.sv
module fce_checks #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sck,
  input logic              abort_evt,
  input logic              finish_evt,
  input logic [7:0]        stat,
  input logic [7:0]        opc,
  input logic              reg_wr,
  input logic [11:0]       reg_addr,
  input logic [31:0]       reg_wdata
);
  // R2: a chip select is only low while a command runs
  a_r2_cs_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1) |-> busy);

  // R2: the end of the tail drops busy
  a_r2_finish_clears: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> !busy);

  // R4: never more than one chip select low
  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  // R3: mode 0, serial clock idles low
  a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  // R8: an aborted start leaves the selects high and flags bit 5
  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> ((cs_n == '1) && stat[5] && !busy));

  // R7: opcode writes during a command are dropped
  a_r7_opcode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 12'h308) |=> $stable(opc));

  // R10: a full clear empties the status
  a_r10_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 12'h12C && reg_wdata[7:0] == 8'hFF && !abort_evt && !finish_evt)
      |=> (stat == 8'h00));
endmodule

bind flash_cmd_engine fce_checks #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .cs_n(cs_n), .sck(sck),
  .abort_evt(abort_evt), .finish_evt(finish_evt), .stat(stat_q), .opc(opc_q),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/sim_flash_cmd_engine.sv
module sim_flash_cmd_engine;
  localparam logic [11:0] A_STAT = 12'h120, A_CLR = 12'h12C, A_VER = 12'h1F8;
  localparam logic [11:0] A_CFG = 12'h300, A_OPC = 12'h308, A_ADR = 12'h30C, A_BUF = 12'h400;

  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, pp_fail = 1'b0, miso = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        sck, mosi;
  logic [3:0]  cs_n;

  flash_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pp_fail(pp_fail), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #10 clk = ~clk;

  int vecs = 0, bad = 0;

  // flash-side responder
  logic [7:0] cap [128];
  logic [7:0] resp [128];
  int bitn = 0, rises = 0, cs_falls = 0, cs_idx = -1;
  realtime t_fall = 0, t_tail = 0;
  wire cs_any_n = &cs_n;

  always @(negedge cs_any_n) begin
    bitn = 0;
    cs_falls++;
    for (int i = 0; i < 4; i++) if (!cs_n[i]) cs_idx = i;
    miso = resp[0][7];
  end
  always @(posedge sck) if (!cs_any_n) begin
    cap[bitn/8][7-(bitn%8)] = mosi;
    bitn++;
    rises++;
  end
  always @(negedge sck) begin
    t_fall = $realtime;
    if (!cs_any_n) miso = resp[(bitn/8)%128][7-(bitn%8)];
  end
  always @(posedge cs_any_n) t_tail = $realtime - t_fall;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] mk_cfg(input int cs, input bit aen, input int dmy,
                                         input bit den, input bit rdn, input int len);
    return (32'(len - 1) << 9) | (32'(rdn) << 8) | (32'(den) << 7) | (32'(dmy) << 4)
         | (32'(aen) << 3) | (32'(cs) << 1) | 32'd1;
  endfunction

  task automatic clear_mon();
    cs_falls = 0; rises = 0; cs_idx = -1;
    for (int i = 0; i < 128; i++) cap[i] = 8'hEE;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] d;
    bit ok = 0;
    for (int i = 0; i < 4000; i++) begin
      rd(A_CFG, d);
      if (!d[0]) begin ok = 1; break; end
    end
    chk(tag, 32'(ok), 32'd1);
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 7 + 3);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CFG, d);  chk("R1 cfg", d, 0);
    rd(A_OPC, d);  chk("R1 opcode", d, 0);
    rd(A_ADR, d);  chk("R1 address", d, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);
    chk("R1 cs_n", 32'(cs_n), 32'hF);
    chk("R1 sck", 32'(sck), 0);
    rd(A_VER, d);  chk("R11 version", d, 32'h350);
  endtask

  task automatic t_write();
    logic [31:0] d;
    logic [7:0] exp [11] = '{8'h02, 8'h12, 8'h34, 8'h56, 8'h00,
                             8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    clear_mon();
    wr(A_OPC, 32'h02); wr(A_ADR, 32'h123456);
    wr(A_BUF, 32'h44332211); wr(A_BUF + 4, 32'h00006655);
    wr(A_CFG, mk_cfg(2, 1, 1, 1, 0, 6));
    rd(A_CFG, d); chk("R2 start reads 1 while busy", 32'(d[0]), 1);
    wait_idle("R2 command completes");
    for (int i = 0; i < 11; i++) chk($sformatf("R3 R5 byte %0d", i), 32'(cap[i]), 32'(exp[i]));
    chk("R3 sck rising edges", rises, 88);
    chk("R4 selected line", cs_idx, 2);
    chk("R2 single select pulse", cs_falls, 1);
    chk("R2 tail in ns", 32'(int'(t_tail)), 40);
  endtask

  task automatic t_read();
    logic [31:0] d;
    clear_mon();
    resp[1] = 8'h5A; resp[2] = 8'h6B; resp[3] = 8'h7C; resp[4] = 8'h8D; resp[5] = 8'h9E;
    wr(A_BUF, 32'h0); wr(A_BUF + 4, 32'hAABBCCDD);
    wr(A_OPC, 32'h03);
    wr(A_CFG, mk_cfg(0, 0, 0, 1, 1, 5));
    wait_idle("R6 read completes");
    chk("R6 opcode sent", 32'(cap[0]), 32'h03);
    rd(A_BUF, d);     chk("R6 word0 packing", d, 32'h8D7C6B5A);
    rd(A_BUF + 4, d); chk("R6 partial word upper kept", d, 32'hAABBCC9E);
    chk("R4 line 0", cs_idx, 0);
    chk("R3 sck rising edges", rises, 48);
  endtask

  task automatic t_busy();
    logic [31:0] d, c;
    clear_mon();
    c = mk_cfg(1, 0, 0, 1, 1, 8);
    wr(A_BUF + 40, 32'h01020304);
    wr(A_OPC, 32'h0B); wr(A_ADR, 32'h000100);
    wr(A_CFG, c);
    wr(A_OPC, 32'h77); wr(A_ADR, 32'hABCDEF);
    wr(A_BUF + 40, 32'hDEADBEEF);
    wr(A_CFG, mk_cfg(3, 0, 0, 0, 0, 1));
    wait_idle("R7 command completes");
    rd(A_OPC, d);     chk("R7 opcode ignored", d, 32'h0B);
    rd(A_ADR, d);     chk("R7 address ignored", d, 32'h000100);
    rd(A_BUF + 40, d); chk("R7 buffer ignored", d, 32'h01020304);
    rd(A_CFG, d);     chk("R7 configuration ignored", d, c & ~32'd1);
    chk("R7 no second start", cs_falls, 1);
    chk("R7 original line kept", cs_idx, 1);
  endtask

  task automatic t_protect();
    logic [31:0] d;
    clear_mon();
    wr(A_OPC, 32'hD8); wr(A_ADR, 32'hFEFFFF);
    wr(A_CFG, mk_cfg(0, 1, 0, 0, 0, 1));
    wait_idle("R8 below window runs");
    chk("R8 below window selects", cs_falls, 1);
    rd(A_STAT, d); chk("R8 below window no flag", d, 0);
    clear_mon();
    wr(A_ADR, 32'hFF0000);
    wr(A_CFG, mk_cfg(0, 1, 0, 0, 0, 1));
    rd(A_CFG, d); chk("R8 start bit clear on abort", 32'(d[0]), 0);
    repeat (40) @(negedge clk);
    chk("R8 no select on abort", cs_falls, 0);
    rd(A_STAT, d); chk("R8 protect flag", d, 32'h20);
  endtask

  task automatic t_ppfail();
    logic [31:0] d;
    wr(A_OPC, 32'h02); wr(A_BUF, 32'h000000A5);
    pp_fail = 1'b1;
    wr(A_CFG, mk_cfg(0, 0, 0, 1, 0, 1));
    wait_idle("R9 write completes");
    rd(A_STAT, d); chk("R9 R10 program flag, protect sticky", d, 32'h24);
    wr(A_CLR, 32'h04);
    rd(A_STAT, d); chk("R10 partial clear", d, 32'h20);
    wr(A_CFG, mk_cfg(0, 0, 0, 1, 1, 2));
    wait_idle("R9 read completes");
    rd(A_STAT, d); chk("R9 no flag on read", d, 32'h20);
    wr(A_CFG, mk_cfg(0, 0, 0, 0, 0, 1));
    wait_idle("R9 opcode-only completes");
    rd(A_STAT, d); chk("R9 no flag without data", d, 32'h20);
    wr(A_CLR, 32'hFF);
    rd(A_STAT, d); chk("R10 full clear", d, 0);
    pp_fail = 1'b0;
  endtask

  task automatic t_full();
    clear_mon();
    for (int i = 0; i < 16; i++)
      wr(A_BUF + 12'(4 * i), {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)});
    wr(A_OPC, 32'h32);
    wr(A_CFG, mk_cfg(3, 0, 0, 1, 0, 64));
    wait_idle("R5 full buffer completes");
    chk("R5 opcode", 32'(cap[0]), 32'h32);
    for (int k = 0; k < 64; k++) chk($sformatf("R5 full byte %0d", k), 32'(cap[k+1]), 32'(pat(k)));
    chk("R3 full sck edges", rises, 520);
    chk("R4 line 3", cs_idx, 3);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 128; i++) resp[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_busy();
    t_protect();
    t_ppfail();
    t_full();
    summary();
  end
endmodule